// File: doc/BRIEF.md
# Segmented Logical Address Translator

This block turns a logical address into a linear address. A logical address is a 16-bit selector and a 32-bit offset. In real mode the selector is shifted left by four bits and added to the offset, and the result is ready one cycle after the start strobe. In protected mode the selector is decoded into a descriptor index and a table choice. The block checks the index against the limit of the chosen table, then reads an 8-byte descriptor as two 32-bit words over a synchronous request/valid memory port.

From the descriptor the block builds a base, a 20-bit limit scaled by the granularity bit, a present bit, the system/code-data bit and a 4-bit type. It checks the present bit first and then the offset against the scaled limit. It then reports either base plus offset or a fault code. Only one translation is in flight at a time. The global and local table base/limit registers are held outside the block and arrive as plain inputs.

Top module: `seg_xlate`

## Requirements
- R1: With `prot_en`=0, a start accepted while idle gives `done` on the next cycle, with `lin_addr` = {12'b0, sel, 4'b0} + off (modulo 2^32), `fault`=0 and no memory read.
- R2: In protected mode, selector bit 2 picks the table: 0 selects the global base/limit and 1 selects the local base/limit. Bits 15:3 are the index. The lower descriptor word is read from base+index*8 and then the upper word from base+index*8+4, one `mem_req` pulse each.
- R3: If index*8+7 is greater than the chosen table limit, `done` comes on the next cycle with `fault`=1 and `lin_addr`=0, and no `mem_req` is raised.
- R4: The descriptor layout is as follows. Lower word: bits 15:0 hold limit[15:0] and bits 31:16 hold base[15:0]. Upper word: bits 7:0 hold base[23:16], bits 11:8 hold the type, bit 12 holds S, bit 15 holds P, bits 19:16 hold limit[19:16], bit 23 holds G and bits 31:24 hold base[31:24].
- R5: A descriptor with P=0 ends with `fault`=2 and `lin_addr`=0.
- R6: The effective limit is the 20-bit limit when G=0 and {limit, 12'hFFF} when G=1. An offset equal to the effective limit is accepted, and a larger one gives `fault`=3 and `lin_addr`=0.
- R7: A successful protected translation gives `lin_addr` = base + off modulo 2^32, with `fault`=0.
- R8: When a descriptor was read, `desc_sys` equals S and `desc_type` equals the type field when `done` is pulsed. In real mode and on a table-limit fault both are 0.
- R9: `busy` is high from the accepted start until `done`. A start while busy is ignored, and each accepted start gives exactly one one-cycle `done` pulse.
- R10: When P=0 and the offset also exceeds the limit, the fault reported is 2.
- R11: After reset, `done`, `busy`, `mem_req`, `fault` and `lin_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a translation (taken only while idle) |
| prot_en | input | 1 | 1 = protected mode, 0 = real mode |
| sel | input | 16 | Selector |
| off | input | 32 | Offset |
| gtab_base | input | 32 | Global table base address |
| gtab_lim | input | 16 | Global table limit (bytes minus one) |
| ltab_base | input | 32 | Local table base address |
| ltab_lim | input | 16 | Local table limit (bytes minus one) |
| mem_req | output | 1 | One-cycle descriptor word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Translation in flight |
| done | output | 1 | One-cycle result strobe |
| lin_addr | output | 32 | Linear address (0 on fault) |
| fault | output | 2 | 0 none, 1 table limit, 2 not present, 3 segment limit |
| desc_sys | output | 1 | S bit of the descriptor that was read |
| desc_type | output | 4 | Type field of the descriptor that was read |

## Verification
The hardest case to reach from the ports is a second start that arrives while a descriptor read is still waiting on memory. The bench holds the memory model at a long read latency, pulses a protected start, and drives a real-mode start with different operands on the next cycle. It then checks that only the first result comes back, and that exactly two reads were made. The bench also uses descriptors whose offsets land exactly on, and one past, the scaled limit under both granularities. It forces the table-limit check at the last in-range index and the first out-of-range index of the local table.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int ADDR_W  = 32;
    localparam int SEL_W   = 16;
    localparam int LIM_W   = 20;
    localparam int TLIM_W  = 16;
    localparam int IDX_W   = SEL_W - 3;
    localparam int PAGE_SH = 12;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_TABLE  = 2'd1,
        FLT_ABSENT = 2'd2,
        FLT_SEGLIM = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_LO,
        ST_WAIT_LO,
        ST_ISSUE_HI,
        ST_WAIT_HI,
        ST_CHECK
    } state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  lim;
        logic              gran;
        logic              present;
        logic              sys;
        logic [3:0]        typ;
    } desc_t;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_xlate_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic              ti,
    input  logic [ADDR_W-1:0] gtab_base,
    input  logic [TLIM_W-1:0] gtab_lim,
    input  logic [ADDR_W-1:0] ltab_base,
    input  logic [TLIM_W-1:0] ltab_lim,
    output logic [ADDR_W-1:0] desc_addr,
    output logic              tab_fault
);
    logic [ADDR_W-1:0] tbase;
    logic [TLIM_W-1:0] tlim;
    logic [TLIM_W-1:0] last_byte;

    always_comb begin
        tbase     = ti ? ltab_base : gtab_base;
        tlim      = ti ? ltab_lim  : gtab_lim;
        last_byte = {idx, 3'b111};
        tab_fault = last_byte > tlim;
        desc_addr = tbase + {{(ADDR_W-TLIM_W){1'b0}}, idx, 3'b000};
    end
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
    import seg_xlate_pkg::*;
(
    input  logic [31:0] word_lo,
    input  logic [31:0] word_hi,
    output desc_t       desc
);
    logic unused_attr;

    always_comb begin
        desc.base    = {word_hi[31:24], word_hi[7:0], word_lo[31:16]};
        desc.lim     = {word_hi[19:16], word_lo[15:0]};
        desc.gran    = word_hi[23];
        desc.present = word_hi[15];
        desc.sys     = word_hi[12];
        desc.typ     = word_hi[11:8];
        unused_attr  = ^{word_hi[22:20], word_hi[14:13]};
    end
endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
(
    input  desc_t             desc,
    input  logic [ADDR_W-1:0] off,
    output fault_e            flt,
    output logic [ADDR_W-1:0] lin
);
    logic [ADDR_W-1:0] eff_lim;

    always_comb begin
        eff_lim = desc.gran ? {desc.lim, {PAGE_SH{1'b1}}}
                            : {{(ADDR_W-LIM_W){1'b0}}, desc.lim};
        if (!desc.present)       flt = FLT_ABSENT;
        else if (off > eff_lim)  flt = FLT_SEGLIM;
        else                     flt = FLT_NONE;
        lin = (flt == FLT_NONE) ? desc.base + off : '0;
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              prot_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] off,
    input  logic [ADDR_W-1:0] gtab_base,
    input  logic [TLIM_W-1:0] gtab_lim,
    input  logic [ADDR_W-1:0] ltab_base,
    input  logic [TLIM_W-1:0] ltab_lim,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] lin_addr,
    output logic [1:0]        fault,
    output logic              desc_sys,
    output logic [3:0]        desc_type
);
    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] daddr;
        logic [ADDR_W-1:0] off;
        logic [31:0]       wlo;
        logic [31:0]       whi;
        logic [ADDR_W-1:0] lin;
        fault_e            flt;
        logic              sys;
        logic [3:0]        typ;
        logic              done;
    } regs_t;

    regs_t d, q;

    logic [ADDR_W-1:0] dec_addr;
    logic              tab_fault;
    desc_t             desc;
    fault_e            chk_flt;
    logic [ADDR_W-1:0] chk_lin;

    seg_sel_decode u_dec (
        .idx(sel[SEL_W-1:3]), .ti(sel[2]),
        .gtab_base(gtab_base), .gtab_lim(gtab_lim),
        .ltab_base(ltab_base), .ltab_lim(ltab_lim),
        .desc_addr(dec_addr), .tab_fault(tab_fault)
    );

    seg_desc_unpack u_unp (.word_lo(q.wlo), .word_hi(q.whi), .desc(desc));

    seg_check u_chk (.desc(desc), .off(q.off), .flt(chk_flt), .lin(chk_lin));

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: if (start) begin
                d.sys = 1'b0;
                d.typ = '0;
                d.off = off;
                if (!prot_en) begin
                    d.lin  = {{(ADDR_W-SEL_W-4){1'b0}}, sel, 4'b0000} + off;
                    d.flt  = FLT_NONE;
                    d.done = 1'b1;
                end else if (tab_fault) begin
                    d.lin  = '0;
                    d.flt  = FLT_TABLE;
                    d.done = 1'b1;
                end else begin
                    d.daddr = dec_addr;
                    d.st    = ST_ISSUE_LO;
                end
            end
            ST_ISSUE_LO: d.st = ST_WAIT_LO;
            ST_WAIT_LO: if (mem_rvalid) begin
                d.wlo = mem_rdata;
                d.st  = ST_ISSUE_HI;
            end
            ST_ISSUE_HI: d.st = ST_WAIT_HI;
            ST_WAIT_HI: if (mem_rvalid) begin
                d.whi = mem_rdata;
                d.st  = ST_CHECK;
            end
            ST_CHECK: begin
                d.lin  = chk_lin;
                d.flt  = chk_flt;
                d.sys  = desc.sys;
                d.typ  = desc.typ;
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.daddr <= '0;
            q.off   <= '0;
            q.wlo   <= '0;
            q.whi   <= '0;
            q.lin   <= '0;
            q.flt   <= FLT_NONE;
            q.sys   <= 1'b0;
            q.typ   <= '0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign mem_req   = (q.st == ST_ISSUE_LO) || (q.st == ST_ISSUE_HI);
    assign mem_addr  = q.daddr + ((q.st == ST_ISSUE_HI) ? 32'd4 : 32'd0);
    assign busy      = q.st != ST_IDLE;
    assign done      = q.done;
    assign lin_addr  = q.lin;
    assign fault     = q.flt;
    assign desc_sys  = q.sys;
    assign desc_type = q.typ;

    a_r1_real_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !prot_en) |=> (done && fault == FLT_NONE && !mem_req));

    a_r3_table_fault_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && prot_en && tab_fault) |=> (done && fault == FLT_TABLE && !mem_req));

    a_r5_fault_no_address: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != FLT_NONE) |-> (lin_addr == '0));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r9_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        prot_en = 1'b0;
    logic [15:0] sel = '0;
    logic [31:0] off = '0;
    logic [31:0] gtab_base = 32'h0000_0100;
    logic [15:0] gtab_lim  = 16'd63;
    logic [31:0] ltab_base = 32'h0000_0200;
    logic [15:0] ltab_lim  = 16'd31;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done;
    logic [31:0] lin_addr;
    logic [1:0]  fault;
    logic        desc_sys;
    logic [3:0]  desc_type;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n), .start(start), .prot_en(prot_en),
        .sel(sel), .off(off),
        .gtab_base(gtab_base), .gtab_lim(gtab_lim),
        .ltab_base(ltab_base), .ltab_lim(ltab_lim),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .lin_addr(lin_addr), .fault(fault),
        .desc_sys(desc_sys), .desc_type(desc_type)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int reads  = 0;
    int dones  = 0;
    int pushes = 0;
    int lat    = 0;
    logic [31:0] rd_addr[2];

    typedef struct {
        logic [31:0] lin;
        logic [1:0]  flt;
        logic        sys;
        logic [3:0]  typ;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic [31:0] mem_w[0:255];

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // memory model: one request in flight, latency set by lat
    logic       pend = 1'b0;
    logic [31:0] paddr = '0;
    int         pcnt = 0;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            rd_addr[reads % 2] <= mem_addr;
            reads <= reads + 1;
            pend  <= 1'b1;
            paddr <= mem_addr;
            pcnt  <= lat;
        end else if (pend) begin
            if (pcnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_w[paddr[9:2]];
                pend       <= 1'b0;
            end else begin
                pcnt <= pcnt - 1;
            end
        end
    end

    // monitor: scoreboard compare
    always @(negedge clk) begin
        if (rst_n && done) begin
            dones++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(lin_addr == e.lin, {e.tag, " lin_addr"}, lin_addr, e.lin);
                chk(fault == e.flt, {e.tag, " fault"}, {30'b0, fault}, {30'b0, e.flt});
                chk(desc_sys == e.sys && desc_type == e.typ, {e.tag, " R8 sys/type"},
                    {27'b0, desc_sys, desc_type}, {27'b0, e.sys, e.typ});
            end
        end
    end

    task automatic put_desc(input logic [31:0] tb, input int idx, input logic [31:0] base,
                            input logic [19:0] lim, input logic g, input logic p,
                            input logic s, input logic [3:0] typ);
        logic [31:0] a;
        a = tb + idx * 8;
        mem_w[a[9:2]]     = {base[15:0], lim[15:0]};
        mem_w[a[9:2] + 1] = {base[31:24], g, 3'b000, lim[19:16], p, 2'b00, s, typ, base[23:16]};
    endtask

    function automatic logic [33:0] model(input logic [31:0] base, input logic [19:0] lim,
                                          input logic g, input logic p, input logic [31:0] o);
        logic [31:0] el;
        el = g ? {lim, 12'hFFF} : {12'h000, lim};
        if (!p)      return {2'd2, 32'h0};
        if (o > el)  return {2'd3, 32'h0};
        return {2'd0, base + o};
    endfunction

    task automatic run(input logic pm, input logic [15:0] s, input logic [31:0] o,
                       input logic [33:0] fl, input logic sy, input logic [3:0] ty,
                       input int exp_reads, input string tag);
        exp_t e;
        int r0;
        e.lin = fl[31:0]; e.flt = fl[33:32]; e.sys = sy; e.typ = ty; e.tag = tag;
        exp_q.push_back(e);
        pushes++;
        r0 = reads;
        @(negedge clk);
        start = 1'b1; prot_en = pm; sel = s; off = o;
        @(negedge clk);
        start = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(reads - r0 == exp_reads, {tag, " read count"}, reads - r0, exp_reads);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem_w[i] = 32'h0;
        // global table at 0x100
        put_desc(32'h100, 1, 32'h0010_0000, 20'h0FFFF, 1'b0, 1'b1, 1'b1, 4'h2);
        put_desc(32'h100, 2, 32'hC000_0000, 20'h00003, 1'b1, 1'b1, 1'b1, 4'hA);
        put_desc(32'h100, 3, 32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 4'h3);
        put_desc(32'h100, 4, 32'h0004_0000, 20'h00010, 1'b0, 1'b0, 1'b1, 4'h2);
        // local table at 0x200
        put_desc(32'h200, 1, 32'h0200_0000, 20'h00100, 1'b0, 1'b1, 1'b0, 4'hB);
        put_desc(32'h200, 3, 32'h0300_0000, 20'h00FFF, 1'b0, 1'b1, 1'b1, 4'h6);

        repeat (3) @(negedge clk);
        chk(!done && !busy && !mem_req && fault == 2'd0 && lin_addr == 32'h0, "R11 reset state",
            {done, busy, mem_req, fault, lin_addr[27:0]}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 real mode
        run(1'b0, 16'h1234, 32'h0000_0010, {2'd0, 32'h0001_2350}, 1'b0, 4'h0, 0, "R1 real");
        run(1'b0, 16'hFFFF, 32'hFFFF_FFF0, {2'd0, 32'h000F_FFE0}, 1'b0, 4'h0, 0, "R1 real wrap");

        // R2 R4 R7 global descriptor, check read addresses
        lat = 0;
        run(1'b1, 16'h0008, 32'h0000_1234, model(32'h0010_0000, 20'h0FFFF, 0, 1, 32'h1234),
            1'b1, 4'h2, 2, "R7 global");
        chk(rd_addr[0] == 32'h108 && rd_addr[1] == 32'h10C, "R2 read addresses",
            rd_addr[1], 32'h10C);
        // RPL bits do not change the result
        run(1'b1, 16'h000B, 32'h0000_1234, model(32'h0010_0000, 20'h0FFFF, 0, 1, 32'h1234),
            1'b1, 4'h2, 2, "R2 rpl ignored");

        // R6 byte granularity boundary
        lat = 2;
        run(1'b1, 16'h0008, 32'h0000_FFFF, model(32'h0010_0000, 20'h0FFFF, 0, 1, 32'hFFFF),
            1'b1, 4'h2, 2, "R6 g0 at limit");
        run(1'b1, 16'h0008, 32'h0001_0000, {2'd3, 32'h0}, 1'b1, 4'h2, 2, "R6 g0 past limit");
        // R6 page granularity boundary
        run(1'b1, 16'h0010, 32'h0000_3FFF, {2'd0, 32'hC000_3FFF}, 1'b1, 4'hA, 2, "R6 g1 at limit");
        run(1'b1, 16'h0010, 32'h0000_4000, {2'd3, 32'h0}, 1'b1, 4'hA, 2, "R6 g1 past limit");
        // R7 wrap
        run(1'b1, 16'h0018, 32'h0000_2000, {2'd0, 32'h0000_1000}, 1'b1, 4'h3, 2, "R7 wrap");

        // R5 not present, R10 priority over limit
        run(1'b1, 16'h0020, 32'h0000_0004, {2'd2, 32'h0}, 1'b1, 4'h2, 2, "R5 absent");
        run(1'b1, 16'h0020, 32'h0000_9000, {2'd2, 32'h0}, 1'b1, 4'h2, 2, "R10 absent over limit");

        // R2 local table selection, R8 system descriptor
        lat = 1;
        run(1'b1, 16'h000C, 32'h0000_0080, {2'd0, 32'h0200_0080}, 1'b0, 4'hB, 2, "R2 local");
        chk(rd_addr[0] == 32'h208 && rd_addr[1] == 32'h20C, "R2 local addresses",
            rd_addr[0], 32'h208);
        run(1'b1, 16'h001C, 32'h0000_0FFF, {2'd0, 32'h0300_0FFF}, 1'b1, 4'h6, 2, "R3 last local index");

        // R3 table limit faults
        run(1'b1, 16'h0040, 32'h0000_0000, {2'd1, 32'h0}, 1'b0, 4'h0, 0, "R3 global past");
        run(1'b1, 16'h0024, 32'h0000_0000, {2'd1, 32'h0}, 1'b0, 4'h0, 0, "R3 local past");

        // R9 start while busy is ignored
        lat = 6;
        begin
            exp_t e;
            int r0, d0;
            e.lin = 32'h0010_0005; e.flt = 2'd0; e.sys = 1'b1; e.typ = 4'h2; e.tag = "R9 busy";
            exp_q.push_back(e);
            pushes++;
            r0 = reads; d0 = dones;
            @(negedge clk);
            start = 1'b1; prot_en = 1'b1; sel = 16'h0008; off = 32'h5;
            @(negedge clk);
            chk(busy, "R9 busy after accept", {31'b0, busy}, 32'd1);
            start = 1'b1; prot_en = 1'b0; sel = 16'h7777; off = 32'h1;
            @(negedge clk);
            start = 1'b0;
            while (exp_q.size() != 0) @(negedge clk);
            repeat (4) @(negedge clk);
            chk(dones - d0 == 1, "R9 one done", dones - d0, 32'd1);
            chk(reads - r0 == 2, "R9 read count", reads - r0, 32'd2);
            chk(!busy, "R9 idle after done", {31'b0, busy}, 32'd0);
        end

        chk(dones == pushes, "R9 total results", dones, pushes);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule